// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home agent for a set of cache lines shared by a few cores. For each line it keeps a directory record: a line state (Uncached, Shared or Modified), a bit vector of cores holding clean copies, and the identity of the core holding a dirty copy. Cores send it read, exclusive-read and write-back requests on a request port. They send invalidation acknowledgements and owner data on a response port. The controller answers on a single registered message port, and on a separate registered port it refuses requests it cannot take yet.

The controller serves one transaction at a time. While a transaction is in flight, any other request is refused, and the requester retries it later. The one exception is a write-back that crosses the controller's own forwarded read or recall. A read to a line that is dirty at another core is forwarded to that owner by default, so the owner supplies the requester directly. A parameter switches this to a recall flow, in which the home collects the line first and then replies itself. An exclusive read invalidates every recorded sharer except the requester, counts the acknowledgements, and only then grants the line. The line data sits in a synchronous single-cycle array that powers up to zero.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset no message and no refusal is issued, every line is Uncached, and a read to any line returns data zero.
- R2: A read (request kind 0) to a line that is not Modified elsewhere returns a shared-data message (kind 0) to the requester carrying the stored data, and adds the requester to the sharer set.
- R3: With FWD3=1, a read to a line Modified at another core sends a forwarded read (kind 2) to the owner, with the requester in the msg_req field. Owner data (response kind 1) updates memory and sends no further message. The line becomes Shared by both cores.
- R4: With FWD3=0, the same read sends a recall (kind 3) to the owner. On owner data the home sends shared data with that value to the requester, and the line becomes Shared by the requester alone.
- R5: An exclusive read (request kind 1) sends exactly one invalidate (kind 4) to each recorded sharer other than the requester, and to no other core.
- R6: The acknowledgement count is the number of sharers other than the requester. Exclusive data (kind 1) is sent only after that many acknowledgements (response kind 0) have arrived, and at once when the count is zero.
- R7: An exclusive read to a line Modified at another core sends a recall to the owner. On owner data the home sends exclusive data with that value, and the requester becomes owner.
- R8: A write-back (request kind 2) from the recorded owner with no transaction pending stores the data, sends no message, and leaves the line Uncached.
- R9: A write-back from a core that is not the recorded owner of a Modified line changes neither data nor directory and sends no message.
- R10: A write-back from the owner while a forwarded read to that line is outstanding is taken as the owner's answer. The requester gets shared data with the written-back value, no refusal is sent, and the line ends Shared by the requester alone.
- R11: A request arriving while a transaction is in flight is refused on the refusal port with its source and line, and leaves no trace in the directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 exclusive read, 2 write-back |
| req_src | input | $clog2(NCORE) | Requesting core |
| req_line | input | $clog2(NLINE) | Line index |
| req_data | input | DW | Write-back data |
| rsp_valid | input | 1 | Response present this cycle |
| rsp_kind | input | 1 | 0 invalidate acknowledgement, 1 owner data |
| rsp_src | input | $clog2(NCORE) | Responding core |
| rsp_data | input | DW | Owner data |
| msg_valid | output | 1 | Message issued this cycle |
| msg_kind | output | 3 | 0 shared data, 1 exclusive data, 2 forwarded read, 3 recall, 4 invalidate |
| msg_dst | output | $clog2(NCORE) | Destination core |
| msg_req | output | $clog2(NCORE) | Original requester, used by forwarded read and recall |
| msg_line | output | $clog2(NLINE) | Line index |
| msg_data | output | DW | Data for data messages |
| nack_valid | output | 1 | Request refused this cycle |
| nack_dst | output | $clog2(NCORE) | Core whose request was refused |
| nack_line | output | $clog2(NLINE) | Line of the refused request |

## Verification
The assertions take for granted that cores behave as coherent caches. Owner data arrives only while the home waits for the owner, and it comes from that owner. Invalidation acknowledgements arrive only for invalidates already sent. A request and a response never carry conflicting information in the same cycle. The bench plays every core itself. It answers forwards, recalls and invalidates only after seeing them on the message port. It sends acknowledgements from exactly the cores that were invalidated, and it never sends unsolicited owner data, so the stimulus stays inside those assumptions while still reaching refusals and the crossing write-back.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {LN_UNC = 2'd0, LN_SHR = 2'd1, LN_MOD = 2'd2} line_st_e;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_READX = 2'd1, RQ_WBACK = 2'd2} req_kind_e;
  typedef enum logic {RS_INV_ACK = 1'b0, RS_OWN_DATA = 1'b1} rsp_kind_e;
  typedef enum logic [2:0] {
    MS_DATA_SH  = 3'd0,
    MS_DATA_EX  = 3'd1,
    MS_FWD_READ = 3'd2,
    MS_RECALL   = 3'd3,
    MS_INV      = 3'd4
  } msg_kind_e;
  typedef enum logic [2:0] {HS_IDLE, HS_MEMRD, HS_INV, HS_ACKW, HS_OWNW} home_st_e;
endpackage

// File: rtl/dir_data_ram.sv
module dir_data_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dir_popcnt.sv
module dir_popcnt #(
  parameter int N  = 4,
  localparam int NW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [NW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int k = 0; k < N; k++) cnt = cnt + NW'(vec[k]);
  end
endmodule

// File: rtl/dir_pick_first.sv
module dir_pick_first #(
  parameter int N  = 4,
  localparam int CW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  oh,
  output logic [CW-1:0] idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign oh[g]       = vec[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | vec[g];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) if (oh[k]) idx = CW'(k);
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 16,
  parameter int DW    = 32,
  parameter bit FWD3  = 1'b1,
  localparam int CW   = $clog2(NCORE),
  localparam int LW   = $clog2(NLINE),
  localparam int NW   = $clog2(NCORE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [CW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  input  logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  input  logic          rsp_kind,
  input  logic [CW-1:0] rsp_src,
  input  logic [DW-1:0] rsp_data,
  output logic          msg_valid,
  output logic [2:0]    msg_kind,
  output logic [CW-1:0] msg_dst,
  output logic [CW-1:0] msg_req,
  output logic [LW-1:0] msg_line,
  output logic [DW-1:0] msg_data,
  output logic          nack_valid,
  output logic [CW-1:0] nack_dst,
  output logic [LW-1:0] nack_line
);
  localparam logic [NCORE-1:0] ONE = NCORE'(1);

  line_st_e         dir_st  [NLINE];
  logic [NCORE-1:0] dir_shr [NLINE];
  logic [CW-1:0]    dir_own [NLINE];

  home_st_e         state_q;
  logic [LW-1:0]    line_q;
  logic [CW-1:0]    req_q;
  logic [CW-1:0]    own_q;
  logic             xcl_q;
  logic [NCORE-1:0] pend_q;
  logic [NW-1:0]    cnt_q;

  line_st_e         cur_st;
  logic [NCORE-1:0] cur_shr;
  logic [CW-1:0]    cur_own;
  logic [NCORE-1:0] src_oh;
  logic [NCORE-1:0] others;
  logic [NW-1:0]    others_cnt;
  logic [NW-1:0]    pend_cnt;
  logic [NCORE-1:0] pick_oh;
  logic [CW-1:0]    pick_idx;
  logic             ack_in;
  logic             own_in;
  logic             race_wb;
  logic             dirty_else;
  logic             wb_ok;
  logic             ram_we;
  logic [LW-1:0]    ram_waddr;
  logic [DW-1:0]    ram_wdata;
  logic [LW-1:0]    ram_raddr;
  logic [DW-1:0]    ram_q;
  logic [DW-1:0]    own_val;

  assign cur_st     = dir_st[req_line];
  assign cur_shr    = dir_shr[req_line];
  assign cur_own    = dir_own[req_line];
  assign src_oh     = ONE << req_src;
  assign others     = (cur_st == LN_SHR) ? (cur_shr & ~src_oh) : '0;
  assign dirty_else = (cur_st == LN_MOD) && (cur_own != req_src);
  assign wb_ok      = (cur_st == LN_MOD) && (cur_own == req_src);
  assign ack_in     = rsp_valid && (rsp_kind == RS_INV_ACK);
  assign own_in     = rsp_valid && (rsp_kind == RS_OWN_DATA);
  assign race_wb    = (state_q == HS_OWNW) && req_valid && (req_kind == RQ_WBACK) &&
                      (req_src == own_q) && (req_line == line_q);
  assign own_val    = race_wb ? req_data : rsp_data;

  dir_popcnt #(.N(NCORE)) u_cnt_others (.vec(others), .cnt(others_cnt));
  dir_popcnt #(.N(NCORE)) u_cnt_pend   (.vec(pend_q), .cnt(pend_cnt));
  dir_pick_first #(.N(NCORE)) u_pick (.vec(pend_q), .oh(pick_oh), .idx(pick_idx));

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = line_q;
    ram_wdata = own_val;
    if (state_q == HS_IDLE) begin
      ram_waddr = req_line;
      ram_wdata = req_data;
      ram_we    = req_valid && (req_kind == RQ_WBACK) && wb_ok;
    end else if (state_q == HS_OWNW) begin
      ram_we = own_in || race_wb;
    end
  end

  assign ram_raddr = (state_q == HS_IDLE) ? req_line : line_q;

  dir_data_ram #(.DW(DW), .DEPTH(NLINE)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= HS_IDLE;
      line_q     <= '0;
      req_q      <= '0;
      own_q      <= '0;
      xcl_q      <= 1'b0;
      pend_q     <= '0;
      cnt_q      <= '0;
      msg_valid  <= 1'b0;
      msg_kind   <= MS_DATA_SH;
      msg_dst    <= '0;
      msg_req    <= '0;
      msg_line   <= '0;
      msg_data   <= '0;
      nack_valid <= 1'b0;
      nack_dst   <= '0;
      nack_line  <= '0;
      for (int k = 0; k < NLINE; k++) begin
        dir_st[k]  <= LN_UNC;
        dir_shr[k] <= '0;
        dir_own[k] <= '0;
      end
    end else begin
      msg_valid  <= 1'b0;
      nack_valid <= 1'b0;
      if (req_valid && (state_q != HS_IDLE) && !race_wb) begin
        nack_valid <= 1'b1;
        nack_dst   <= req_src;
        nack_line  <= req_line;
      end
      case (state_q)
        HS_IDLE: begin
          if (req_valid) begin
            line_q <= req_line;
            req_q  <= req_src;
            if (req_kind == RQ_READ) begin
              xcl_q <= 1'b0;
              if (dirty_else) begin
                own_q     <= cur_own;
                msg_valid <= 1'b1;
                msg_kind  <= FWD3 ? MS_FWD_READ : MS_RECALL;
                msg_dst   <= cur_own;
                msg_req   <= req_src;
                msg_line  <= req_line;
                msg_data  <= '0;
                state_q   <= HS_OWNW;
              end else begin
                dir_st[req_line]  <= LN_SHR;
                dir_shr[req_line] <= ((cur_st == LN_MOD) ? '0 : cur_shr) | src_oh;
                state_q           <= HS_MEMRD;
              end
            end else if (req_kind == RQ_READX) begin
              xcl_q <= 1'b1;
              if (dirty_else) begin
                own_q     <= cur_own;
                cnt_q     <= '0;
                msg_valid <= 1'b1;
                msg_kind  <= MS_RECALL;
                msg_dst   <= cur_own;
                msg_req   <= req_src;
                msg_line  <= req_line;
                msg_data  <= '0;
                state_q   <= HS_OWNW;
              end else begin
                dir_st[req_line]  <= LN_MOD;
                dir_shr[req_line] <= '0;
                dir_own[req_line] <= req_src;
                pend_q            <= others;
                cnt_q             <= others_cnt;
                state_q           <= (others_cnt == '0) ? HS_MEMRD : HS_INV;
              end
            end else if (req_kind == RQ_WBACK && wb_ok) begin
              dir_st[req_line]  <= LN_UNC;
              dir_shr[req_line] <= '0;
              dir_own[req_line] <= '0;
            end
          end
        end
        HS_MEMRD: begin
          msg_valid <= 1'b1;
          msg_kind  <= xcl_q ? MS_DATA_EX : MS_DATA_SH;
          msg_dst   <= req_q;
          msg_req   <= req_q;
          msg_line  <= line_q;
          msg_data  <= ram_q;
          state_q   <= HS_IDLE;
        end
        HS_INV: begin
          msg_valid <= 1'b1;
          msg_kind  <= MS_INV;
          msg_dst   <= pick_idx;
          msg_req   <= req_q;
          msg_line  <= line_q;
          msg_data  <= '0;
          pend_q    <= pend_q & ~pick_oh;
          if (ack_in) cnt_q <= cnt_q - NW'(1);
          if ((pend_q & ~pick_oh) == '0) state_q <= HS_ACKW;
        end
        HS_ACKW: begin
          if (cnt_q == '0) state_q <= HS_MEMRD;
          else if (ack_in) cnt_q <= cnt_q - NW'(1);
        end
        HS_OWNW: begin
          if (own_in || race_wb) begin
            state_q <= HS_IDLE;
            if (xcl_q) begin
              msg_valid       <= 1'b1;
              msg_kind        <= MS_DATA_EX;
              msg_dst         <= req_q;
              msg_req         <= req_q;
              msg_line        <= line_q;
              msg_data        <= own_val;
              dir_st[line_q]  <= LN_MOD;
              dir_shr[line_q] <= '0;
              dir_own[line_q] <= req_q;
            end else if (race_wb || !FWD3) begin
              msg_valid       <= 1'b1;
              msg_kind        <= MS_DATA_SH;
              msg_dst         <= req_q;
              msg_req         <= req_q;
              msg_line        <= line_q;
              msg_data        <= own_val;
              dir_st[line_q]  <= LN_SHR;
              dir_shr[line_q] <= ONE << req_q;
              dir_own[line_q] <= '0;
            end else begin
              dir_st[line_q]  <= LN_SHR;
              dir_shr[line_q] <= (ONE << req_q) | (ONE << own_q);
              dir_own[line_q] <= '0;
            end
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  p_fwd_not_self_r3: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && (msg_kind == MS_FWD_READ || msg_kind == MS_RECALL)) |-> (msg_dst != msg_req));

  p_own_data_expected_r3: assert property (@(posedge clk) disable iff (rst)
    own_in |-> (state_q == HS_OWNW && rsp_src == own_q));

  p_inv_not_req_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == MS_INV) |-> (msg_dst != req_q));

  p_pend_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_INV) |-> (pend_cnt <= cnt_q));

  p_no_ack_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_in && (state_q == HS_INV || state_q == HS_ACKW)) |-> (cnt_q != '0));

  p_ex_fill_after_acks_r6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == MS_DATA_EX) |-> (cnt_q == '0));

  p_nack_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
    nack_valid |-> ($past(state_q) != HS_IDLE));
endmodule

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
  localparam int NC = 4;
  localparam int NL = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst;

  logic          rq_v [2];
  logic [1:0]    rq_k [2];
  logic [1:0]    rq_s [2];
  logic [3:0]    rq_l [2];
  logic [DW-1:0] rq_d [2];
  logic          rs_v [2];
  logic          rs_k [2];
  logic [1:0]    rs_s [2];
  logic [DW-1:0] rs_d [2];
  logic          mv   [2];
  logic [2:0]    mk   [2];
  logic [1:0]    md   [2];
  logic [1:0]    mr   [2];
  logic [3:0]    ml   [2];
  logic [DW-1:0] mdat [2];
  logic          nv   [2];
  logic [1:0]    nd   [2];
  logic [3:0]    nl   [2];

  dir_home_ctrl #(.NCORE(NC), .NLINE(NL), .DW(DW), .FWD3(1'b1)) u_dir_home_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(rq_v[0]), .req_kind(rq_k[0]), .req_src(rq_s[0]), .req_line(rq_l[0]), .req_data(rq_d[0]),
    .rsp_valid(rs_v[0]), .rsp_kind(rs_k[0]), .rsp_src(rs_s[0]), .rsp_data(rs_d[0]),
    .msg_valid(mv[0]), .msg_kind(mk[0]), .msg_dst(md[0]), .msg_req(mr[0]), .msg_line(ml[0]),
    .msg_data(mdat[0]), .nack_valid(nv[0]), .nack_dst(nd[0]), .nack_line(nl[0]));

  dir_home_ctrl #(.NCORE(NC), .NLINE(NL), .DW(DW), .FWD3(1'b0)) u_dir_home_ctrl_rc (
    .clk(clk), .rst(rst),
    .req_valid(rq_v[1]), .req_kind(rq_k[1]), .req_src(rq_s[1]), .req_line(rq_l[1]), .req_data(rq_d[1]),
    .rsp_valid(rs_v[1]), .rsp_kind(rs_k[1]), .rsp_src(rs_s[1]), .rsp_data(rs_d[1]),
    .msg_valid(mv[1]), .msg_kind(mk[1]), .msg_dst(md[1]), .msg_req(mr[1]), .msg_line(ml[1]),
    .msg_data(mdat[1]), .nack_valid(nv[1]), .nack_dst(nd[1]), .nack_line(nl[1]));

  int          tot_msg  [2];
  int          tot_nack [2];
  int          tot_inv  [2][NC];
  logic [2:0]  last_k   [2];
  logic [1:0]  last_d   [2];
  logic [1:0]  last_r   [2];
  logic [DW-1:0] last_dat [2];
  logic [1:0]  last_nd  [2];
  logic [3:0]  last_nl  [2];
  int          s_msg    [2];
  int          s_nack   [2];
  int          s_inv    [2][NC];
  int          chk_n  = 0;
  int          fail_n = 0;

  initial begin
    for (int i = 0; i < 2; i++) begin
      tot_msg[i] = 0;
      tot_nack[i] = 0;
      for (int c = 0; c < NC; c++) tot_inv[i][c] = 0;
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst && mv[i]) begin
        if (mk[i] == 3'd4) tot_inv[i][md[i]] = tot_inv[i][md[i]] + 1;
        else begin
          tot_msg[i]  = tot_msg[i] + 1;
          last_k[i]   = mk[i];
          last_d[i]   = md[i];
          last_r[i]   = mr[i];
          last_dat[i] = mdat[i];
        end
      end
      if (!rst && nv[i]) begin
        tot_nack[i] = tot_nack[i] + 1;
        last_nd[i]  = nd[i];
        last_nl[i]  = nl[i];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mark(input int i);
    @(posedge clk);
    s_msg[i]  = tot_msg[i];
    s_nack[i] = tot_nack[i];
    for (int c = 0; c < NC; c++) s_inv[i][c] = tot_inv[i][c];
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic req(input int i, input logic [1:0] k, input int s, input int l, input logic [31:0] d);
    @(negedge clk);
    rq_v[i] = 1'b1; rq_k[i] = k; rq_s[i] = 2'(s); rq_l[i] = 4'(l); rq_d[i] = d;
    @(negedge clk);
    rq_v[i] = 1'b0;
  endtask

  task automatic rsp(input int i, input logic k, input int s, input logic [31:0] d);
    @(negedge clk);
    rs_v[i] = 1'b1; rs_k[i] = k; rs_s[i] = 2'(s); rs_d[i] = d;
    @(negedge clk);
    rs_v[i] = 1'b0;
  endtask

  function automatic int new_msgs(input int i);
    return tot_msg[i] - s_msg[i];
  endfunction

  function automatic logic [3:0] inv_mask(input int i);
    logic [3:0] m = '0;
    for (int c = 0; c < NC; c++) if (tot_inv[i][c] != s_inv[i][c]) m[c] = 1'b1;
    return m;
  endfunction

  function automatic int inv_total(input int i);
    int t = 0;
    for (int c = 0; c < NC; c++) t += tot_inv[i][c] - s_inv[i][c];
    return t;
  endfunction

  // issue a request and expect exactly one data message of kind k to dst with data d
  task automatic expect_data(input int i, input logic [1:0] rk, input int src, input int line,
                             input logic [2:0] k, input logic [31:0] d, input string tag);
    mark(i);
    req(i, rk, src, line, 32'h0);
    settle(4);
    chk(new_msgs(i) == 1 && last_k[i] == k && last_d[i] == 2'(src) && last_dat[i] == d,
        tag, {last_k[i], 1'b0, last_d[i], last_dat[i][23:0]}, {k, 1'b0, 2'(src), d[23:0]});
  endtask

  // exclusive read that invalidates mask m, then acknowledges and expects the fill
  task automatic excl_flow(input int i, input int src, input int line, input logic [3:0] m,
                           input logic [31:0] d, input string tag);
    mark(i);
    req(i, 2'd1, src, line, 32'h0);
    settle(6);
    chk(inv_mask(i) == m && inv_total(i) == $countones(m), tag, {28'h0, inv_mask(i)}, {28'h0, m});
    for (int c = 0; c < NC; c++) if (m[c]) rsp(i, 1'b0, c, 32'h0);
    settle(4);
    chk(new_msgs(i) == 1 && last_k[i] == 3'd1 && last_d[i] == 2'(src) && last_dat[i] == d,
        tag, last_dat[i], d);
  endtask

  initial begin
    rst = 1'b1;
    for (int i = 0; i < 2; i++) begin
      rq_v[i] = 0; rq_k[i] = 0; rq_s[i] = 0; rq_l[i] = 0; rq_d[i] = 0;
      rs_v[i] = 0; rs_k[i] = 0; rs_s[i] = 0; rs_d[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    chk(!mv[0] && !mv[1] && !nv[0] && !nv[1], "R1 reset outputs idle",
        {mv[0], mv[1], nv[0], nv[1]}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2: sweep every line with a read from core line%4, data zero after reset
    for (int l = 0; l < NL; l++) expect_data(0, 2'd0, l % NC, l, 3'd0, 32'h0, "R1 R2 sweep read");

    // R2: grow line 1 sharers to all cores
    expect_data(0, 2'd0, 0, 1, 3'd0, 32'h0, "R2 read adds sharer");
    expect_data(0, 2'd0, 2, 1, 3'd0, 32'h0, "R2 read adds sharer");
    expect_data(0, 2'd0, 3, 1, 3'd0, 32'h0, "R2 read adds sharer");

    // R5 R6 R11: exclusive read by core 2 on line 1
    mark(0);
    req(0, 2'd1, 2, 1, 32'h0);
    settle(6);
    chk(inv_mask(0) == 4'b1011 && inv_total(0) == 3, "R5 invalidate set", inv_mask(0), 4'b1011);
    chk(new_msgs(0) == 0, "R6 no fill before acks", new_msgs(0), 0);
    rsp(0, 1'b0, 0, 32'h0);
    rsp(0, 1'b0, 1, 32'h0);
    settle(4);
    chk(new_msgs(0) == 0, "R6 no fill after partial acks", new_msgs(0), 0);
    mark(0);
    req(0, 2'd0, 0, 5, 32'h0);
    settle(2);
    chk(tot_nack[0] - s_nack[0] == 1 && last_nd[0] == 2'd0 && last_nl[0] == 4'd5,
        "R11 busy refusal", {last_nd[0], last_nl[0]}, {2'd0, 4'd5});
    rsp(0, 1'b0, 3, 32'h0);
    settle(4);
    chk(new_msgs(0) == 1 && last_k[0] == 3'd1 && last_d[0] == 2'd2, "R6 fill after last ack",
        {last_k[0], last_d[0]}, {3'd1, 2'd2});

    // R11: retry succeeds and refused request left no trace before it
    expect_data(0, 2'd0, 0, 5, 3'd0, 32'h0, "R11 retry read");
    excl_flow(0, 3, 5, 4'b0011, 32'h0, "R11 sharers after retry");

    // R6: sole sharer upgrade needs no invalidate
    mark(0);
    req(0, 2'd1, 2, 2, 32'h0);
    settle(4);
    chk(inv_total(0) == 0 && new_msgs(0) == 1 && last_k[0] == 3'd1 && last_d[0] == 2'd2,
        "R6 zero count fills at once", inv_total(0), 0);

    // R8: owner write-back, then read from memory
    mark(0);
    req(0, 2'd2, 2, 1, 32'hA1);
    settle(3);
    chk(new_msgs(0) == 0 && inv_total(0) == 0, "R8 write-back silent", new_msgs(0), 0);
    expect_data(0, 2'd0, 0, 1, 3'd0, 32'hA1, "R8 read after write-back");

    // R9: stray write-back ignored
    mark(0);
    req(0, 2'd2, 3, 1, 32'hBAD);
    settle(3);
    chk(new_msgs(0) == 0 && tot_nack[0] == s_nack[0], "R9 stray write-back silent", new_msgs(0), 0);
    expect_data(0, 2'd0, 1, 1, 3'd0, 32'hA1, "R9 data unchanged");

    // R3: three-hop forwarded read on line 3
    excl_flow(0, 0, 3, 4'b1000, 32'h0, "R5 single sharer");
    mark(0);
    req(0, 2'd0, 1, 3, 32'h0);
    settle(3);
    chk(new_msgs(0) == 1 && last_k[0] == 3'd2 && last_d[0] == 2'd0 && last_r[0] == 2'd1,
        "R3 forward to owner", {last_k[0], last_d[0], last_r[0]}, {3'd2, 2'd0, 2'd1});
    mark(0);
    rsp(0, 1'b1, 0, 32'h33);
    settle(4);
    chk(new_msgs(0) == 0, "R3 no reply from home", new_msgs(0), 0);
    excl_flow(0, 2, 3, 4'b0011, 32'h33, "R3 both sharers and memory");

    // R10: write-back crosses forwarded read on line 2 (owner 2)
    mark(0);
    req(0, 2'd0, 3, 2, 32'h0);
    settle(3);
    chk(last_k[0] == 3'd2 && last_d[0] == 2'd2 && last_r[0] == 2'd3, "R10 forward issued",
        {last_k[0], last_d[0]}, {3'd2, 2'd2});
    mark(0);
    req(0, 2'd2, 2, 2, 32'h77);
    settle(4);
    chk(new_msgs(0) == 1 && last_k[0] == 3'd0 && last_d[0] == 2'd3 && last_dat[0] == 32'h77 &&
        tot_nack[0] == s_nack[0], "R10 write-back answers forward", last_dat[0], 32'h77);
    excl_flow(0, 1, 2, 4'b1000, 32'h77, "R10 only requester shares");

    // R4: recall flow on the second instance, line 4
    expect_data(1, 2'd1, 1, 4, 3'd1, 32'h0, "R6 exclusive on uncached");
    mark(1);
    req(1, 2'd0, 2, 4, 32'h0);
    settle(3);
    chk(new_msgs(1) == 1 && last_k[1] == 3'd3 && last_d[1] == 2'd1 && last_r[1] == 2'd2,
        "R4 recall to owner", {last_k[1], last_d[1], last_r[1]}, {3'd3, 2'd1, 2'd2});
    mark(1);
    rsp(1, 1'b1, 1, 32'h44);
    settle(4);
    chk(new_msgs(1) == 1 && last_k[1] == 3'd0 && last_d[1] == 2'd2 && last_dat[1] == 32'h44,
        "R4 home replies", last_dat[1], 32'h44);
    excl_flow(1, 3, 4, 4'b0100, 32'h44, "R4 owner dropped");

    // R7: exclusive read to a dirty line, line 6
    expect_data(1, 2'd1, 0, 6, 3'd1, 32'h0, "R7 first owner");
    mark(1);
    req(1, 2'd1, 3, 6, 32'h0);
    settle(3);
    chk(new_msgs(1) == 1 && last_k[1] == 3'd3 && last_d[1] == 2'd0 && last_r[1] == 2'd3,
        "R7 recall for exclusive", {last_k[1], last_d[1]}, {3'd3, 2'd0});
    mark(1);
    rsp(1, 1'b1, 0, 32'h66);
    settle(4);
    chk(new_msgs(1) == 1 && last_k[1] == 3'd1 && last_d[1] == 2'd3 && last_dat[1] == 32'h66,
        "R7 exclusive fill with owner data", last_dat[1], 32'h66);
    mark(1);
    req(1, 2'd2, 3, 6, 32'h67);
    settle(3);
    chk(new_msgs(1) == 0, "R8 new owner write-back silent", new_msgs(1), 0);
    expect_data(1, 2'd0, 1, 6, 3'd0, 32'h67, "R8 data after new owner write-back");

    $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", chk_n - fail_n, chk_n + 1);
    $finish;
  end
endmodule